// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches the receive byte stream of an Ethernet MAC while the MAC is parked in a wake-on-LAN state. Software sets a wake-mode bit once it has stopped both the receive and the transmit path. From then on every received byte is marked for discard, so no frame reaches the normal receive path. Meanwhile a scanner looks inside each frame for the wake pattern: a run of 0xFF sync bytes, then the station address repeated a fixed number of times.

When a frame that holds the pattern ends with a good CRC, the block clears the wake-mode bit by itself. It also sets a sticky wake event. Software clears that event by writing one. The event reaches the interrupt line only when its mask bit is set. Scanning runs only while reception is enabled. Matches found in frames with a bad CRC are dropped.

Top module: `mpkt_wake_top`

## Requirements
- R1: After reset, wake_mode, wake_event, wake_irq and frame_drop are all 0.
- R2: A write with arm_wr=1 and arm_val=1 sets wake_mode on the next clock edge only when grs_done and gts_done are both 1. Otherwise the write leaves wake_mode unchanged. A write with arm_val=0 clears wake_mode.
- R3: frame_drop is 1 for every rx_valid byte while wake_mode is 1, and 0 while wake_mode is 0.
- R4: While rx_enable is 0, no frame can clear wake_mode or set wake_event.
- R5: The wake pattern is SYNC_LEN (6) bytes of 0xFF followed at once by COPIES (16) back-to-back copies of station_addr. Each copy is sent most significant byte first, so station_addr[47:40] comes first. The pattern may start at any byte offset in the frame, and a longer run of 0xFF before it is accepted.
- R6: A partial match that is broken by a wrong byte restarts the search. A 0xFF byte at the break counts as the first sync byte of a new run, and any other byte sets the sync count to zero.
- R7: A frame counts as a wake frame only if rx_crc_ok is 1 in the cycle that carries its rx_eof byte.
- R8: On the clock edge that ends a wake frame, wake_mode goes to 0 and wake_event goes to 1.
- R9: wake_event stays set until a cycle with evt_clr=1. If a wake frame ends in the same cycle as evt_clr, the set wins.
- R10: wake_irq is 1 exactly when wake_event is 1 and evt_mask is 1.
- R11: Progress toward a match never carries over between frames. The state clears at rx_eof and at rx_sof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte strobe |
| rx_sof | input | 1 | First byte of a frame (with rx_valid) |
| rx_eof | input | 1 | Last byte of a frame (with rx_valid) |
| rx_data | input | 8 | Receive byte |
| rx_crc_ok | input | 1 | CRC result, valid with the rx_eof byte |
| station_addr | input | 48 | Station address, first byte in bits 47:40 |
| rx_enable | input | 1 | Frame reception enabled |
| arm_wr | input | 1 | Software write strobe for the wake-mode bit |
| arm_val | input | 1 | Value written to the wake-mode bit |
| grs_done | input | 1 | Graceful receive stop complete |
| gts_done | input | 1 | Graceful transmit stop complete |
| evt_clr | input | 1 | Write-one-to-clear pulse for wake_event |
| evt_mask | input | 1 | Interrupt mask bit, 1 = enabled |
| frame_drop | output | 1 | Discard the current byte's frame |
| wake_mode | output | 1 | Wake-mode bit, cleared by hardware on a match |
| wake_event | output | 1 | Sticky wake event |
| wake_irq | output | 1 | Masked wake interrupt |

## Verification
frame_drop and wake_irq are combinational. The bench samples frame_drop one time unit after it drives each byte on the falling edge, and samples wake_irq right after it changes evt_mask. wake_mode and wake_event are registered, so they change on the rising edge that takes in the arm write, the evt_clr pulse or the rx_eof byte. The bench drives every stimulus on a falling edge and reads these two outputs on the next falling edge, which is one cycle after the stimulus. Each table entry sends one whole frame and then compares wake_mode and wake_event at that point with the expected match result.

// File: rtl/mpkt_pkg.sv
package mpkt_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'hFF;

  typedef enum logic {
    PH_HUNT = 1'b0,
    PH_ADDR = 1'b1
  } scan_phase_e;
endpackage

// File: rtl/mpkt_scan.sv
module mpkt_scan
  import mpkt_pkg::*;
#(
  parameter int SYNC_LEN   = 6,
  parameter int ADDR_BYTES = 6,
  parameter int COPIES     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scan_en,
  input  logic                    byte_stb,
  input  logic                    sof,
  input  logic                    eof,
  input  logic [7:0]              data,
  input  logic                    crc_ok,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  output logic                    magic_hit
);
  localparam int AW = 8 * ADDR_BYTES;
  localparam int CW = $clog2(SYNC_LEN + 1);
  localparam int PW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int KW = (COPIES > 1) ? $clog2(COPIES) : 1;

  // byte idx of the address as it appears on the wire (idx 0 = MSB byte)
  function automatic logic [7:0] addr_byte(input logic [AW-1:0] a, input logic [PW-1:0] idx);
    logic [AW-1:0] sh;
    sh = a << (8 * int'(idx));
    return sh[AW-1 -: 8];
  endfunction

  // sync run counter: saturates at SYNC_LEN, any non-0xFF byte zeroes it
  function automatic logic [CW-1:0] sync_step(input logic [CW-1:0] c, input logic [7:0] d);
    if (d != SYNC_BYTE)            return '0;
    else if (c == CW'(SYNC_LEN))   return c;
    else                           return c + 1'b1;
  endfunction

  scan_phase_e     ph_q,  ph_b,  ph_d;
  logic [CW-1:0]   ff_q,  ff_b,  ff_d;
  logic [PW-1:0]   pos_q, pos_b, pos_d;
  logic [KW-1:0]   cp_q,  cp_b,  cp_d;
  logic            m_q,   m_b,   m_d;
  logic            step_go;
  logic [PW-1:0]   step_pos;
  logic [KW-1:0]   step_cp;
  logic            start_frame;

  assign start_frame = byte_stb && sof;

  always_comb begin
    // a start byte begins from a clean state
    ph_b  = start_frame ? PH_HUNT : ph_q;
    ff_b  = start_frame ? '0 : ff_q;
    pos_b = start_frame ? '0 : pos_q;
    cp_b  = start_frame ? '0 : cp_q;
    m_b   = start_frame ? 1'b0 : m_q;

    ph_d = ph_b; ff_d = ff_b; pos_d = pos_b; cp_d = cp_b; m_d = m_b;
    step_go = 1'b0; step_pos = pos_b; step_cp = cp_b;

    if (byte_stb) begin
      if (ph_b == PH_HUNT) begin
        if (ff_b == CW'(SYNC_LEN) && data == addr_byte(station_addr, '0)) begin
          step_go = 1'b1; step_pos = '0; step_cp = '0;
        end else begin
          ff_d = sync_step(ff_b, data);
        end
      end else begin
        if (data == addr_byte(station_addr, pos_b)) begin
          step_go = 1'b1;
        end else begin
          ph_d  = PH_HUNT;
          ff_d  = sync_step('0, data);
          pos_d = '0;
          cp_d  = '0;
        end
      end

      if (step_go) begin
        if (int'(step_pos) == ADDR_BYTES - 1) begin
          if (int'(step_cp) == COPIES - 1) begin
            m_d = 1'b1; ph_d = PH_HUNT; ff_d = '0; pos_d = '0; cp_d = '0;
          end else begin
            ph_d = PH_ADDR; pos_d = '0; cp_d = step_cp + 1'b1;
          end
        end else begin
          ph_d = PH_ADDR; pos_d = step_pos + 1'b1; cp_d = step_cp;
        end
      end
    end
  end

  assign magic_hit = scan_en && byte_stb && eof && crc_ok && m_d;

  always_ff @(posedge clk) begin
    if (!rst_n || !scan_en || (byte_stb && eof)) begin
      ph_q <= PH_HUNT; ff_q <= '0; pos_q <= '0; cp_q <= '0; m_q <= 1'b0;
    end else if (byte_stb) begin
      ph_q <= ph_d; ff_q <= ff_d; pos_q <= pos_d; cp_q <= cp_d; m_q <= m_d;
    end
  end

  // R4: scanning halted means no partial progress survives
  a_r4_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (ff_q == '0 && !m_q && ph_q == PH_HUNT));

  // R11: nothing found in one frame is kept past its end byte
  a_r11_eof_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && eof) |=> (!m_q && ph_q == PH_HUNT && cp_q == '0));
endmodule

// File: rtl/mpkt_ctrl.sv
module mpkt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_wr,
  input  logic arm_val,
  input  logic grs_done,
  input  logic gts_done,
  input  logic magic_hit,
  input  logic evt_clr,
  input  logic evt_mask,
  output logic wake_mode,
  output logic wake_event,
  output logic wake_irq
);
  logic arm_accept;
  logic disarm_req;

  assign arm_accept = arm_wr && arm_val && grs_done && gts_done;
  assign disarm_req = arm_wr && !arm_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_mode <= 1'b0;
    end else if (magic_hit || disarm_req) begin
      wake_mode <= 1'b0;
    end else if (arm_accept) begin
      wake_mode <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_event <= 1'b0;
    end else if (magic_hit) begin
      wake_event <= 1'b1;
    end else if (evt_clr) begin
      wake_event <= 1'b0;
    end
  end

  assign wake_irq = wake_event && evt_mask;

  // R2: mode only turns on after a write seen with both stops complete
  a_r2_arm_needs_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_mode) |-> $past(arm_wr && arm_val && grs_done && gts_done));

  // R8: a hit drops the mode bit and raises the event one edge later
  a_r8_hit_effect: assert property (@(posedge clk) disable iff (!rst_n)
    magic_hit |=> (!wake_mode && wake_event));

  // R9: the event holds unless a clear is written
  a_r9_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_event && !evt_clr) |=> wake_event);
endmodule

// File: rtl/mpkt_wake_top.sv
module mpkt_wake_top #(
  parameter int SYNC_LEN   = 6,
  parameter int ADDR_BYTES = 6,
  parameter int COPIES     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic                    rx_eof,
  input  logic [7:0]              rx_data,
  input  logic                    rx_crc_ok,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic                    rx_enable,
  input  logic                    arm_wr,
  input  logic                    arm_val,
  input  logic                    grs_done,
  input  logic                    gts_done,
  input  logic                    evt_clr,
  input  logic                    evt_mask,
  output logic                    frame_drop,
  output logic                    wake_mode,
  output logic                    wake_event,
  output logic                    wake_irq
);
  logic scan_en;
  logic magic_hit;

  assign scan_en    = wake_mode && rx_enable;
  assign frame_drop = wake_mode && rx_valid;

  mpkt_scan #(
    .SYNC_LEN  (SYNC_LEN),
    .ADDR_BYTES(ADDR_BYTES),
    .COPIES    (COPIES)
  ) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_en     (scan_en),
    .byte_stb    (rx_valid),
    .sof         (rx_sof),
    .eof         (rx_eof),
    .data        (rx_data),
    .crc_ok      (rx_crc_ok),
    .station_addr(station_addr),
    .magic_hit   (magic_hit)
  );

  mpkt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_wr    (arm_wr),
    .arm_val   (arm_val),
    .grs_done  (grs_done),
    .gts_done  (gts_done),
    .magic_hit (magic_hit),
    .evt_clr   (evt_clr),
    .evt_mask  (evt_mask),
    .wake_mode (wake_mode),
    .wake_event(wake_event),
    .wake_irq  (wake_irq)
  );

  // R7: a hit only ever comes from a good-CRC end byte while armed and enabled
  a_r7_hit_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    magic_hit |-> (rx_valid && rx_eof && rx_crc_ok && rx_enable && wake_mode));

  // R3: while armed, every received byte is flagged for discard
  a_r3_drop_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_mode && rx_valid) |-> frame_drop);
endmodule

// File: tb/mpkt_wake_top_test.sv
module mpkt_wake_top_test;
  localparam logic [47:0] ADDR = 48'h02_1A_3C_4D_5E_6F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_ok = 0;
  logic [7:0] rx_data = 8'h00;
  logic rx_enable = 1, arm_wr = 0, arm_val = 0, grs_done = 0, gts_done = 0;
  logic evt_clr = 0, evt_mask = 0;
  logic frame_drop, wake_mode, wake_event, wake_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] fbuf [0:255];
  int flen;
  bit clr_on_eof = 0;

  always #5 clk = ~clk;

  mpkt_wake_top uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_crc_ok(rx_crc_ok), .station_addr(ADDR), .rx_enable(rx_enable),
    .arm_wr(arm_wr), .arm_val(arm_val), .grs_done(grs_done), .gts_done(gts_done),
    .evt_clr(evt_clr), .evt_mask(evt_mask), .frame_drop(frame_drop),
    .wake_mode(wake_mode), .wake_event(wake_event), .wake_irq(wake_irq)
  );

  typedef struct packed {
    logic [7:0] pre;
    logic [7:0] nff1;
    logic [7:0] ncp1;
    logic       brk_en;
    logic [7:0] brk;
    logic [7:0] nff2;
    logic [7:0] ncp2;
    logic       crc;
    logic       ren;
    logic       exp_wake;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [0:NV-1] = '{
    '{8'd0, 8'd6, 8'd16, 1'b0, 8'h00, 8'd0, 8'd0,  1'b1, 1'b1, 1'b1}, // R5 plain
    '{8'd9, 8'd6, 8'd16, 1'b0, 8'h00, 8'd0, 8'd0,  1'b1, 1'b1, 1'b1}, // R5 offset
    '{8'd3, 8'd9, 8'd16, 1'b0, 8'h00, 8'd0, 8'd0,  1'b1, 1'b1, 1'b1}, // R5 long sync run
    '{8'd2, 8'd5, 8'd16, 1'b0, 8'h00, 8'd0, 8'd0,  1'b1, 1'b1, 1'b0}, // R5 short sync
    '{8'd2, 8'd6, 8'd15, 1'b0, 8'h00, 8'd0, 8'd0,  1'b1, 1'b1, 1'b0}, // R5 one copy short
    '{8'd1, 8'd6, 8'd17, 1'b0, 8'h00, 8'd0, 8'd0,  1'b1, 1'b1, 1'b1}, // R5 extra copy
    '{8'd0, 8'd6, 8'd1,  1'b1, 8'h00, 8'd6, 8'd16, 1'b1, 1'b1, 1'b1}, // R6 restart full
    '{8'd0, 8'd6, 8'd2,  1'b1, 8'hFF, 8'd5, 8'd16, 1'b1, 1'b1, 1'b1}, // R6 ff counts
    '{8'd0, 8'd6, 8'd1,  1'b1, 8'h00, 8'd5, 8'd16, 1'b1, 1'b1, 1'b0}, // R6 zero resets
    '{8'd4, 8'd6, 8'd16, 1'b0, 8'h00, 8'd0, 8'd0,  1'b0, 1'b1, 1'b0}, // R7 bad crc
    '{8'd4, 8'd6, 8'd16, 1'b0, 8'h00, 8'd0, 8'd0,  1'b1, 1'b0, 1'b0}, // R4 rx disabled
    '{8'd0, 8'd6, 8'd3,  1'b1, 8'h12, 8'd7, 8'd16, 1'b1, 1'b1, 1'b1}  // R6 break then long run
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] abyte(input int i);
    return ADDR[47 - 8*i -: 8];
  endfunction

  task automatic put(input logic [7:0] b);
    fbuf[flen] = b;
    flen++;
  endtask

  task automatic put_copies(input int n);
    for (int c = 0; c < n; c++)
      for (int i = 0; i < 6; i++) put(abyte(i));
  endtask

  // sends fbuf[0:flen-1]; returns 1 if frame_drop matched exp_drop on every byte
  task automatic send_frame(input logic crc, input logic exp_drop, output bit drop_ok);
    drop_ok = 1;
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fbuf[i];
      rx_sof = (i == 0); rx_eof = (i == flen - 1);
      rx_crc_ok = (i == flen - 1) ? crc : 1'b0;
      evt_clr = (i == flen - 1) ? clr_on_eof : 1'b0;
      #1;
      if (frame_drop !== exp_drop) drop_ok = 0;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_ok = 0; evt_clr = 0;
  endtask

  task automatic arm_write(input logic v, input logic g, input logic t);
    @(negedge clk);
    arm_wr = 1; arm_val = v; grs_done = g; gts_done = t;
    @(negedge clk);
    arm_wr = 0; grs_done = 0; gts_done = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    evt_clr = 1;
    @(negedge clk);
    evt_clr = 0;
  endtask

  task automatic build_magic();
    flen = 0;
    put(8'h55); put(8'h66);
    for (int i = 0; i < 6; i++) put(8'hFF);
    put_copies(16);
    put(8'h77);
  endtask

  initial begin
    bit ok;
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "wake_mode", {7'd0, wake_mode}, 8'd0);
    chk("R1", "wake_event", {7'd0, wake_event}, 8'd0);
    chk("R1", "wake_irq", {7'd0, wake_irq}, 8'd0);
    chk("R1", "frame_drop", {7'd0, frame_drop}, 8'd0);

    // R2 arm rejected without both stops
    arm_write(1, 1, 0);
    chk("R2", "arm with rx stop only", {7'd0, wake_mode}, 8'd0);
    arm_write(1, 0, 1);
    chk("R2", "arm with tx stop only", {7'd0, wake_mode}, 8'd0);

    // R3 disarmed: frames pass, magic frame has no effect
    build_magic();
    send_frame(1, 0, ok);
    chk("R3", "no drop while disarmed", {7'd0, ok}, 8'd1);
    chk("R3", "no event while disarmed", {7'd0, wake_event}, 8'd0);

    arm_write(1, 1, 1);
    chk("R2", "arm with both stops", {7'd0, wake_mode}, 8'd1);
    arm_write(0, 0, 0);
    chk("R2", "disarm write", {7'd0, wake_mode}, 8'd0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      v = TBL[k];
      arm_write(1, 1, 1);
      if (wake_event) pulse_clr();
      rx_enable = v.ren;
      flen = 0;
      for (int i = 0; i < int'(v.pre); i++) put(8'h55);
      for (int i = 0; i < int'(v.nff1); i++) put(8'hFF);
      put_copies(int'(v.ncp1));
      if (v.brk_en) begin
        for (int i = 0; i < 3; i++) put(abyte(i));
        put(v.brk);
        for (int i = 0; i < int'(v.nff2); i++) put(8'hFF);
        put_copies(int'(v.ncp2));
      end
      put(8'h33); put(8'h44);
      send_frame(v.crc, 1, ok);
      chk("R3", $sformatf("vec %0d drop every byte", k), {7'd0, ok}, 8'd1);
      chk("R8", $sformatf("vec %0d wake_mode", k), {7'd0, wake_mode}, {7'd0, !v.exp_wake});
      chk("R5", $sformatf("vec %0d wake_event", k), {7'd0, wake_event}, {7'd0, v.exp_wake});
      rx_enable = 1;
      arm_write(0, 0, 0);
    end

    // R11: progress split across two frames does not combine
    arm_write(1, 1, 1);
    pulse_clr();
    flen = 0;
    for (int i = 0; i < 6; i++) put(8'hFF);
    put_copies(10);
    put(8'h99);
    send_frame(1, 1, ok);
    flen = 0;
    put_copies(6);
    put(8'h99);
    send_frame(1, 1, ok);
    chk("R11", "split pattern no wake", {7'd0, wake_mode}, 8'd1);
    chk("R11", "split pattern no event", {7'd0, wake_event}, 8'd0);

    // R10 / R9: mask and stickiness
    build_magic();
    send_frame(1, 1, ok);
    chk("R8", "directed wake clears mode", {7'd0, wake_mode}, 8'd0);
    evt_mask = 0; #1;
    chk("R10", "masked irq", {7'd0, wake_irq}, 8'd0);
    evt_mask = 1; #1;
    chk("R10", "unmasked irq", {7'd0, wake_irq}, 8'd1);
    repeat (5) @(negedge clk);
    chk("R9", "event sticky", {7'd0, wake_event}, 8'd1);
    pulse_clr();
    chk("R9", "event cleared", {7'd0, wake_event}, 8'd0);
    chk("R10", "irq follows clear", {7'd0, wake_irq}, 8'd0);

    // R9: set wins over a simultaneous clear
    arm_write(1, 1, 1);
    clr_on_eof = 1;
    build_magic();
    send_frame(1, 1, ok);
    clr_on_eof = 0;
    chk("R9", "set beats clear", {7'd0, wake_event}, 8'd1);
    chk("R8", "mode cleared again", {7'd0, wake_mode}, 8'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule